// File: doc/BRIEF.md
# Byte-Paced I2C Master

This block is a single-master I2C controller driven through four byte-wide registers. Software sets a bit to put a START on the bus, writes bytes to shift them out, and reads bytes to pull them in. Each byte ends in an acknowledge slot and raises a completion flag, which can also drive an interrupt line. Clearing the master bit ends the transfer with a STOP. Setting the master bit again together with a restart bit produces a repeated START.

Reception is paced by software. Each read of the data register returns the byte that has already arrived and launches the next one. The first read after an address byte is therefore a throwaway read that only starts the first data byte. Software chooses the acknowledge level one byte ahead. Setting the direction bit back to transmit before the final read stops any further byte from being fetched.

The bus lines are open-drain: an `_oe` output high pulls that line low. One bit time is four quarter periods, and each quarter lasts `div + 1` clock cycles. The block also watches the bus for START and STOP conditions from any master, loses arbitration cleanly, and waits for a busy bus before it starts.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, all four registers read as follows. Status (address 1) reads 0x01: bit 0 done = 1, bit 1 flag, bit 2 busy, bit 3 arbitration lost and bit 4 received-NACK all 0. Control (address 0) reads 0x00. Both bus lines are released and `irq` is low.
- R2: A control write (address 0) with bit 0 enable and bit 2 master set, when master was clear and the bus is free, produces a START. SDA falls while SCL is high, and SCL falls `div + 1` cycles later. The divider is register address 3.
- R3: In transmit mode (control bit 3 = 1), a write to the data register (address 2) shifts that byte out MSB first. SDA holds steady while SCL is high, and the SCL period is `4 * (div + 1)` cycles. On the ninth clock SDA is released and the sampled level is stored in status bit 4 (1 = NACK).
- R4: The end of every byte sets status bit 1. `irq` equals that bit gated by control bit 1. A status write clears bit 1 wherever the written bit 1 is 0.
- R5: In receive mode (control bit 3 = 0, master set), a data-register read returns the last completed byte and launches reception of the next byte.
- R6: On the ninth clock of a received byte, the block drives SDA low (ACK) when control bit 4 was 0 at launch, and releases it (NACK) when that bit was 1.
- R7: A data-register read while control bit 3 = 1 launches no byte. No SCL edge follows, and status done stays 1 with flag 0.
- R8: A control write that clears bit 2 while a transfer is held produces a STOP. SDA rises `div + 1` cycles after SCL rises, and busy (status bit 2) then clears.
- R9: A control write with bits 0, 2 and 5 (restart) set, while master is already set and the bus is held, produces a repeated START. SDA falls with SCL high, and SCL falls `div + 1` cycles later, with no STOP in between.
- R10: If SDA reads low while the block is releasing it for a transmitted data bit, status bit 3 and bit 1 are set and control bit 2 clears. Both lines are released at once.
- R11: A control write with bit 0 = 0 clears all control bits and releases both lines from the next cycle. Any byte in progress is abandoned, so status done reads 1.
- R12: Status bit 2 sets on any START seen on the bus and clears on any STOP. A START requested while it is set is held back until it clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect on data register only) |
| addr | input | 2 | Register select: 0 control, 1 status, 2 data, 3 divider |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Completion interrupt |
| scl_i | input | 1 | SCL level on the bus |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_i | input | 1 | SDA level on the bus |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The hardest situation to reach from the ports is arbitration loss. It needs a second driver that pulls SDA low exactly while the block is releasing a data bit. The bench has an extra open-drain driver for this. It asserts that driver after the START has finished and SCL is low, then writes a byte whose MSB is 1, so the first sample of bit 0 sees the conflict. The same extra driver is used to fake another master's START and STOP, which exercises the busy tracking and the held-back START.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int DIV_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  input  logic       scl_i,
  output logic       scl_oe,
  input  logic       sda_i,
  output logic       sda_oe
);
  localparam logic [1:0] A_CTL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2, A_DIV = 2'd3;
  localparam logic [5:0] Q_BYTE_LAST = 6'd35;

  typedef enum logic [1:0] {S_IDLE, S_HOLD, S_SEQ} st_t;
  typedef enum logic [1:0] {OP_START, OP_RSTART, OP_STOP, OP_BYTE} op_t;
  typedef enum logic [1:0] {P_NONE, P_START, P_STOP, P_RSTART} pend_t;

  logic en, ie, mst, txm, txnack;
  logic [DIV_W-1:0] div_q, cnt;
  logic [7:0] dreg, shreg;
  logic [5:0] q, q_last;
  st_t   st;
  op_t   op;
  pend_t pend;
  logic go, flag, arbl, rxnack, busy, bytetx, ackbit, smp;
  logic scl_s, sda_s, sda_p;
  logic scl_rel, sda_rel;

  wire [3:0] bitn    = q[5:2];
  wire [1:0] ph      = q[1:0];
  wire       in_byte = (st == S_SEQ) && (op == OP_BYTE);
  wire       tick    = (st == S_SEQ) && (cnt == div_q);
  wire       ctl_wr  = wr_en && addr == A_CTL;
  wire       arb_hit = tick && in_byte && ph == 2'd2 && bitn < 4'd8 && bytetx && shreg[7] && !sda_i;

  always_comb
    case (op)
      OP_START, OP_STOP: q_last = 6'd2;
      OP_RSTART:         q_last = 6'd3;
      default:           q_last = Q_BYTE_LAST;
    endcase

  always_comb begin
    scl_rel = 1'b1;
    sda_rel = 1'b1;
    if (st == S_HOLD) begin
      scl_rel = 1'b0;
      sda_rel = 1'b0;
    end else if (st == S_SEQ) begin
      case (op)
        OP_START:  begin scl_rel = q != 6'd2;              sda_rel = q == 6'd0; end
        OP_RSTART: begin scl_rel = q == 6'd1 || q == 6'd2; sda_rel = q < 6'd2;  end
        OP_STOP:   begin scl_rel = q != 6'd0;              sda_rel = q == 6'd2; end
        default: begin
          scl_rel = ph == 2'd1 || ph == 2'd2;
          sda_rel = (bitn == 4'd8) ? (bytetx || ackbit) : shreg[7];
        end
      endcase
    end
  end

  assign scl_oe = !scl_rel;
  assign sda_oe = !sda_rel;
  assign irq    = ie && flag;

  always_comb
    case (addr)
      A_CTL:   rdata = {3'b0, txnack, txm, mst, ie, en};
      A_STAT:  rdata = {3'b0, rxnack, arbl, busy, flag, !in_byte};
      A_DATA:  rdata = dreg;
      default: rdata = 8'(div_q);
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= 1'b1; sda_s <= 1'b1; sda_p <= 1'b1; busy <= 1'b0;
    end else begin
      scl_s <= scl_i;
      sda_s <= sda_i;
      sda_p <= sda_s;
      if (scl_s && sda_p && !sda_s)      busy <= 1'b1;
      else if (scl_s && !sda_p && sda_s) busy <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {en, ie, mst, txm, txnack} <= '0;
      div_q <= '0; cnt <= '0; q <= '0;
      dreg <= '0; shreg <= '0;
      st <= S_IDLE; op <= OP_START; pend <= P_NONE;
      {go, flag, arbl, rxnack, bytetx, ackbit, smp} <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (en && pend == P_START && !busy) begin
            st <= S_SEQ; op <= OP_START; q <= '0; cnt <= '0; pend <= P_NONE;
          end
        S_HOLD:
          if (pend == P_STOP || pend == P_RSTART) begin
            st <= S_SEQ; op <= (pend == P_STOP) ? OP_STOP : OP_RSTART;
            q <= '0; cnt <= '0; pend <= P_NONE;
          end else if (go) begin
            st <= S_SEQ; op <= OP_BYTE; q <= '0; cnt <= '0; go <= 1'b0;
            shreg <= txm ? dreg : 8'hFF;
            bytetx <= txm;
            ackbit <= txnack;
          end
        default:
          if (tick) begin
            cnt <= '0;
            if (op == OP_BYTE && ph == 2'd2 && bitn < 4'd8) smp <= sda_i;
            if (op == OP_BYTE && ph == 2'd2 && bitn == 4'd8 && bytetx) rxnack <= sda_i;
            if (op == OP_BYTE && ph == 2'd3 && bitn < 4'd8) shreg <= {shreg[6:0], smp};
            if (arb_hit) begin
              st <= S_IDLE; arbl <= 1'b1; flag <= 1'b1; mst <= 1'b0;
              pend <= P_NONE; go <= 1'b0;
            end else if (q == q_last) begin
              st <= (op == OP_STOP) ? S_IDLE : S_HOLD;
              if (op == OP_BYTE) begin
                flag <= 1'b1;
                dreg <= shreg;
              end
            end else begin
              q <= q + 6'd1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
      endcase

      if (wr_en && addr == A_DIV) div_q <= DIV_W'(wdata);
      if (wr_en && addr == A_STAT) begin
        flag <= flag && wdata[1];
        arbl <= arbl && wdata[3];
      end
      if (wr_en && addr == A_DATA) begin
        dreg <= wdata;
        if (en && txm) go <= 1'b1;
      end
      if (rd_en && addr == A_DATA && en && mst && !txm) go <= 1'b1;

      if (ctl_wr) begin
        if (!wdata[0]) begin
          {en, ie, mst, txm, txnack} <= '0;
          st <= S_IDLE; pend <= P_NONE; go <= 1'b0;
        end else begin
          en <= 1'b1; ie <= wdata[1]; mst <= wdata[2]; txm <= wdata[3]; txnack <= wdata[4];
          if (wdata[2] && !mst && st == S_IDLE)  pend <= P_START;
          else if (!wdata[2] && mst)             pend <= (st == S_IDLE) ? P_NONE : P_STOP;
          else if (wdata[2] && mst && wdata[5])  pend <= P_RSTART;
        end
      end
    end
endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] addr,
  input logic [7:0] wdata,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       in_byte,
  input logic       flag,
  input logic       arbl
);
  AST_DISABLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0 && !wdata[0]) |=> (!scl_oe && !sda_oe)); // R11

  AST_ARB_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arbl) |-> (!scl_oe && !sda_oe)); // R10

  AST_FLAG_FROM_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(in_byte)); // R4

  AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_byte && $past(in_byte) && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe)); // R3
endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .in_byte(in_byte), .flag(flag), .arbl(arbl)
);

// File: tb/i2c_byte_master_bench.sv
module i2c_byte_master_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  wire  [7:0] rdata;
  wire  irq, scl_oe, sda_oe;
  logic ext_sda = 1'b0;
  wire  slv_drive;
  wire  scl_bus = !scl_oe;
  wire  sda_bus = !(sda_oe || slv_drive || ext_sda);

  i2c_byte_master u_i2c_byte_master (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq),
    .scl_i(scl_bus), .scl_oe(scl_oe), .sda_i(sda_bus), .sda_oe(sda_oe)
  );

  int vectors = 0, errors = 0;
  bit finished = 1'b0;

  // open-drain target model
  int bitc = 0;
  bit fresh = 1'b0, active = 1'b0;
  logic [7:0] s_rx = 8'd0, s_byte = 8'd0;
  bit s_tx = 1'b0, s_ack = 1'b1;
  logic ack_seen = 1'b1;
  int n_start = 0, n_stop = 0, n_sclr = 0;
  time t_sda_f = 0, t_sda_r = 0, t_scl_f = 0, t_scl_r = 0, t_scl_r_prev = 0;

  always @(negedge sda_bus) begin
    t_sda_f = $time;
    if (scl_bus) begin n_start++; bitc = 0; fresh = 1'b1; active = 1'b1; end
  end
  always @(posedge sda_bus) begin
    t_sda_r = $time;
    if (scl_bus) begin n_stop++; active = 1'b0; end
  end
  always @(posedge scl_bus) begin
    t_scl_r_prev = t_scl_r;
    t_scl_r = $time;
    n_sclr++;
    if (active) begin
      if (bitc < 8) s_rx = {s_rx[6:0], sda_bus};
      else ack_seen = sda_bus;
    end
  end
  always @(negedge scl_bus) begin
    t_scl_f = $time;
    if (fresh) fresh = 1'b0;
    else if (active) bitc = (bitc == 8) ? 0 : bitc + 1;
  end
  assign slv_drive = active && (s_tx ? (bitc < 8 && !s_byte[3'(7 - bitc)]) : (bitc == 8 && s_ack));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 3000) begin @(negedge clk); n++; end
    chk(req, 32'(irq), 32'd1);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(2'd1, v); chk("R1 status", 32'(v), 32'h01);
    rd(2'd0, v); chk("R1 control", 32'(v), 32'h00);
    chk("R1 lines", 32'({scl_bus, sda_bus, irq}), 32'b110);
  endtask

  task automatic t_start;
    logic [7:0] v;
    wr(2'd3, 8'd3);
    wr(2'd0, 8'h0F);
    idle(20);
    chk("R2 start hold", 32'(t_scl_f - t_sda_f), 32'd40);
    chk("R2 start seen", 32'(n_start), 32'd1);
    rd(2'd1, v); chk("R12 busy after start", 32'(v[2]), 32'd1);
  endtask

  task automatic t_write;
    logic [7:0] v;
    s_tx = 1'b0; s_ack = 1'b1;
    wr(2'd2, 8'h54);
    wait_irq("R4 irq after byte");
    chk("R3 byte on bus", 32'(s_rx), 32'h54);
    chk("R3 scl period", 32'(t_scl_r - t_scl_r_prev), 32'd160);
    rd(2'd1, v); chk("R4 status after ack", 32'(v), 32'h07);
    wr(2'd1, 8'h00); chk("R4 irq cleared", 32'(irq), 32'd0);
    s_ack = 1'b0;
    wr(2'd2, 8'hA5);
    wait_irq("R4 irq second byte");
    chk("R3 second byte", 32'(s_rx), 32'hA5);
    rd(2'd1, v); chk("R3 nack recorded", 32'(v[4]), 32'd1);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_read;
    logic [7:0] v;
    int n;
    s_ack = 1'b1;
    wr(2'd0, 8'h2F);
    idle(30);
    chk("R9 restart seen", 32'(n_start), 32'd2);
    chk("R9 no stop", 32'(n_stop), 32'd0);
    chk("R9 restart hold", 32'(t_scl_f - t_sda_f), 32'd40);
    wr(2'd2, 8'h55);
    wait_irq("R4 irq address");
    wr(2'd1, 8'h00);
    s_tx = 1'b1; s_byte = 8'hC3;
    wr(2'd0, 8'h07);
    rd(2'd2, v);
    wait_irq("R5 first byte done");
    chk("R6 ack driven", 32'(ack_seen), 32'd0);
    wr(2'd1, 8'h00);
    s_byte = 8'h3C;
    wr(2'd0, 8'h17);
    rd(2'd2, v); chk("R5 first byte value", 32'(v), 32'hC3);
    wait_irq("R5 second byte done");
    chk("R6 nack driven", 32'(ack_seen), 32'd1);
    wr(2'd1, 8'h00);
    s_tx = 1'b0; s_ack = 1'b0;
    wr(2'd0, 8'h0F);
    n = n_sclr;
    rd(2'd2, v); chk("R5 last byte value", 32'(v), 32'h3C);
    idle(100);
    chk("R7 no clocks", 32'(n_sclr), 32'(n));
    rd(2'd1, v); chk("R7 idle status", 32'(v[1:0]), 32'b01);
  endtask

  task automatic t_stop;
    logic [7:0] v;
    wr(2'd0, 8'h0B);
    idle(30);
    chk("R8 stop setup", 32'(t_sda_r - t_scl_r), 32'd40);
    chk("R8 stop seen", 32'(n_stop), 32'd1);
    rd(2'd1, v); chk("R8 busy cleared", 32'(v[2]), 32'd0);
    chk("R8 lines released", 32'({scl_bus, sda_bus}), 32'b11);
  endtask

  task automatic t_busy;
    logic [7:0] v;
    int ns;
    ext_sda = 1'b1;
    idle(5);
    rd(2'd1, v); chk("R12 foreign start", 32'(v[2]), 32'd1);
    wr(2'd0, 8'h0F);
    idle(60);
    chk("R12 start held", 32'({scl_oe, sda_oe}), 32'd0);
    ns = n_start;
    ext_sda = 1'b0;
    idle(40);
    chk("R12 start after stop", 32'(n_start), 32'(ns + 1));
    wr(2'd0, 8'h0B);
    idle(30);
  endtask

  task automatic t_arb;
    logic [7:0] v;
    wr(2'd0, 8'h0F);
    idle(20);
    ext_sda = 1'b1;
    s_tx = 1'b0; s_ack = 1'b0;
    wr(2'd2, 8'h80);
    wait_irq("R10 irq on loss");
    rd(2'd1, v); chk("R10 arb flag", 32'(v[3]), 32'd1);
    rd(2'd0, v); chk("R10 master dropped", 32'(v[2]), 32'd0);
    chk("R10 lines released", 32'({scl_oe, sda_oe}), 32'd0);
    ext_sda = 1'b0;
    idle(10);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_disable;
    logic [7:0] v;
    wr(2'd0, 8'h0F);
    idle(20);
    wr(2'd2, 8'hF0);
    idle(40);
    wr(2'd0, 8'h00);
    chk("R11 lines released", 32'({scl_oe, sda_oe}), 32'd0);
    rd(2'd1, v); chk("R11 done", 32'(v[0]), 32'd1);
    rd(2'd0, v); chk("R11 control cleared", 32'(v), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_start;
    t_write;
    t_read;
    t_stop;
    t_busy;
    t_arb;
    t_disable;
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      vectors++;
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule